// File: doc/BRIEF.md
# Serial Peripheral Master with Queues and Two-Stage Clock Divider

This block is the data path of a synchronous serial master. Words written into an eight-entry transmit queue are shifted out most significant bit first on `mosi`, while `miso` is sampled into a receive shift register and the result is stored in an eight-entry receive queue. The word length can be set anywhere from 4 to 16 bits. Clock idle level and sampling phase are set through two configuration inputs.

The serial clock comes from two dividers in series: an even prescale value (its lowest bit is ignored) and a rate value `scr` that divides by `scr+1`. One bit therefore lasts `prescale*(scr+1)` system clocks, and each half bit lasts `(prescale/2)*(scr+1)` clocks. When the receive queue is full, the controller keeps shifting. It drops each completed word and raises a sticky overrun flag, which a clear pulse resets. Two DMA request outputs report room in the transmit queue and data in the receive queue.

A master enable starts and stops frame issue. `busy` covers every frame in progress, including the last one after the transmit queue has drained.

Top module: `spi_master_ctrl`

## Requirements
- R1: A half bit lasts (prescale[7:1])*(scr+1) clock cycles, so sclk rises every prescale*(scr+1) cycles within a frame. prescale bit 0 is ignored, and a prescale of 0 or 1 acts as 2.
- R2: A frame carries len_m1+1 bits, MSB first, with len_m1 clamped to 3..15. The received word is right-aligned with zeros above, so with miso tied to mosi it equals the sent word masked to the frame length.
- R3: While idle, sclk rests at cpol. cpha=0 samples on the leading edge of each bit and cpha=1 on the trailing edge. All four modes round-trip correctly in loopback.
- R4: cs_n goes low when a frame is loaded and stays low for the whole frame. With cpha=0, mosi already carries the MSB before the first sclk edge.
- R5: The transmit queue holds 8 words. tx_not_full is 0 while 8 words are queued, and a write while full is discarded.
- R6: The receive queue holds 8 words. rx_not_empty reports data, rx_data shows the oldest word, and an rx_rd pulse removes it.
- R7: A frame that completes while the receive queue is full is discarded and sets overrun. Shifting of queued frames continues.
- R8: overrun stays at 1 until a one-cycle overrun_clr pulse. Reads do not clear it.
- R9: busy is 1 from the load of a frame until half a bit after the last queued frame completes, including while the transmit queue is already empty. It is 0 when idle.
- R10: With enable at 0 no new frame starts: busy stays 0 and cs_n stays 1 while words wait in the transmit queue.
- R11: tx_dma_req = tx_dma_en and tx_not_full. rx_dma_req = rx_dma_en and rx_not_empty.
- R12: With the receive queue empty, rx_data reads 0 and an rx_rd pulse changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new frames to start |
| cpol | input | 1 | Idle level of sclk |
| cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| len_m1 | input | 4 | Frame length minus one (clamped 3..15) |
| prescale | input | 8 | Even prescale value, bit 0 ignored |
| scr | input | 8 | Rate divider, divides by scr+1 |
| tx_wr | input | 1 | Push tx_data into the transmit queue |
| tx_data | input | 16 | Word to send, right-aligned |
| tx_not_full | output | 1 | Transmit queue has room |
| rx_rd | input | 1 | Pop the oldest received word |
| rx_data | output | 16 | Oldest received word, 0 when empty |
| rx_not_empty | output | 1 | Receive queue holds data |
| busy | output | 1 | A frame is in progress |
| overrun | output | 1 | Sticky receive overrun flag |
| overrun_clr | input | 1 | Clears the overrun flag |
| tx_dma_en | input | 1 | Enables the transmit DMA request |
| rx_dma_en | input | 1 | Enables the receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low select, low during frames |

## Verification
A divider counter that is off by one shows up at the first sclk edge of a frame, as a rise spacing different from prescale*(scr+1). A wrong edge index or a misaligned shift register shows up as a corrupted loopback word once that frame is read. Queue pointer or count errors become visible only when a queue reaches its boundary: the ninth write, the ninth received word, or a read from an empty queue. For that reason the bench fills both queues exactly and reads back the full contents. A stuck state machine shows as busy never falling, or cs_n rising in the middle of a frame.

// File: rtl/spi_pkg.sv
package spi_pkg;
   localparam int MIN_BITS = 4;
   typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} xfer_state_e;
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             rd,
   output logic [WIDTH-1:0] rdata,
   output logic             full,
   output logic             empty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [PW-1:0] ONE_P = 1;
   localparam logic [PW-1:0] LAST_P = PW'(DEPTH - 1);
   localparam logic [CW-1:0] ONE_C = 1;
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("spi_fifo: DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wp, rp, wp_nx, rp_nx;
   logic [CW-1:0]    count;
   logic             do_wr, do_rd;

   assign full  = (count == DEPTH_C);
   assign empty = (count == '0);
   assign do_wr = wr && !full;
   assign do_rd = rd && !empty;
   assign rdata = empty ? '0 : mem[rp];

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wp_nx = wp + ONE_P;
      assign rp_nx = rp + ONE_P;
   end else begin : g_wrap
      assign wp_nx = (wp == LAST_P) ? '0 : wp + ONE_P;
      assign rp_nx = (rp == LAST_P) ? '0 : rp + ONE_P;
   end

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_wr) wp <= wp_nx;
         if (do_rd) rp <= rp_nx;
         if (do_wr && !do_rd)      count <= count + ONE_C;
         else if (do_rd && !do_wr) count <= count - ONE_C;
      end
   end

   // R5: a write into a full queue leaves the fill level alone
   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && full && !rd) |=> full);
   // R12: a read from an empty queue leaves it empty
   a_r12_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && empty && !wr) |=> empty);
endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv #(
   parameter int PRE_W = 8,
   parameter int SCR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRE_W-1:0] prescale,
   input  logic [SCR_W-1:0] scr,
   output logic             tick
);
   localparam int HW = PRE_W - 1;
   localparam logic [HW-1:0]    ONE_H = 1;
   localparam logic [SCR_W-1:0] ONE_S = 1;

   if (PRE_W < 2) begin : g_bad_pre
      $error("spi_clkdiv: PRE_W must be at least 2");
   end

   logic [HW-1:0]    half_eff, c_pre;
   logic [SCR_W-1:0] c_scr;
   logic             pre_wrap;

   // Bit 0 of the prescaler is dropped: the half-bit count is prescale/2
   assign half_eff = (prescale[PRE_W-1:1] == '0) ? ONE_H : prescale[PRE_W-1:1];
   assign pre_wrap = (c_pre == half_eff - ONE_H);
   assign tick     = run && pre_wrap && (c_scr == scr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_pre <= '0;
         c_scr <= '0;
      end else if (!run) begin
         c_pre <= '0;
         c_scr <= '0;
      end else if (pre_wrap) begin
         c_pre <= '0;
         c_scr <= (c_scr == scr) ? '0 : c_scr + ONE_S;
      end else begin
         c_pre <= c_pre + ONE_H;
      end
   end

   // R1: with a divide ratio above one, ticks never come back to back
   a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (half_eff != ONE_H || scr != '0)) |=> !tick);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
   import spi_pkg::*;
#(
   parameter int MAX_BITS = 16,
   parameter int LEN_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic                cpol,
   input  logic                cpha,
   input  logic [LEN_W-1:0]    len_m1,
   input  logic                tick,
   input  logic                tx_empty,
   input  logic [MAX_BITS-1:0] tx_word,
   output logic                tx_pop,
   output logic                busy,
   output logic                done,
   output logic [MAX_BITS-1:0] rx_word,
   output logic                sclk,
   output logic                mosi,
   input  logic                miso,
   output logic                cs_n
);
   localparam int EW = LEN_W + 2;
   localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_BITS - 1);
   localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_BITS - 1);
   localparam logic [LEN_W:0]   ONE_N   = 1;
   localparam logic [LEN_W:0]   MAX_N   = (LEN_W + 1)'(MAX_BITS);
   localparam logic [EW-1:0]    ONE_E   = 1;

   if (MAX_BITS < MIN_BITS || (1 << LEN_W) < MAX_BITS) begin : g_bad_len
      $error("spi_shifter: MAX_BITS and LEN_W are inconsistent");
   end

   xfer_state_e         state;
   logic [LEN_W-1:0]    len_c;
   logic [LEN_W:0]      nbits;
   logic [EW-1:0]       edge_ix, last_edge;
   logic [MAX_BITS-1:0] tx_sh, rx_sh;
   logic                lvl, start, samp_e, shift_e, last_e;

   assign len_c     = (len_m1 < LEN_MIN) ? LEN_MIN : (len_m1 > LEN_MAX) ? LEN_MAX : len_m1;
   assign nbits     = {1'b0, len_c} + ONE_N;
   assign last_edge = {nbits, 1'b0} - ONE_E;
   assign start     = enable && !tx_empty &&
                      ((state == ST_IDLE) || (state == ST_GAP && tick));
   // Even edges lead a bit, odd edges trail it
   assign samp_e    = cpha ? edge_ix[0] : !edge_ix[0];
   assign shift_e   = cpha ? (!edge_ix[0] && edge_ix != '0) : edge_ix[0];
   assign last_e    = (edge_ix == last_edge);

   assign tx_pop  = start;
   assign busy    = (state != ST_IDLE);
   assign cs_n    = (state == ST_IDLE);
   assign sclk    = cpol ^ lvl;
   assign mosi    = tx_sh[MAX_BITS-1];
   assign rx_word = rx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         edge_ix <= '0;
         lvl     <= 1'b0;
         tx_sh   <= '0;
         rx_sh   <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            state   <= ST_SHIFT;
            edge_ix <= '0;
            lvl     <= 1'b0;
            tx_sh   <= tx_word << (MAX_N - nbits);
            rx_sh   <= '0;
         end else if (state == ST_SHIFT && tick) begin
            lvl <= !lvl;
            if (samp_e)  rx_sh <= {rx_sh[MAX_BITS-2:0], miso};
            if (shift_e) tx_sh <= {tx_sh[MAX_BITS-2:0], 1'b0};
            if (last_e) begin
               state <= ST_GAP;
               done  <= 1'b1;
            end else begin
               edge_ix <= edge_ix + ONE_E;
            end
         end else if (state == ST_GAP && tick) begin
            state <= ST_IDLE;
         end
      end
   end

   // R3: each frame ends with an even number of edges, so sclk is back at rest
   a_r3_clock_rests: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (lvl == 1'b0));
   // R9: a completed frame is reported while busy still holds
   a_r9_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
   // R2: the edge index stays within the frame
   a_r2_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SHIFT) |-> (edge_ix <= last_edge));
   // R4: select cannot rise in the middle of a frame
   a_r4_cs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SHIFT && !(tick && last_e)) |=> !cs_n);
endmodule

// File: rtl/spi_master_ctrl.sv
module spi_master_ctrl #(
   parameter int MAX_BITS = 16,
   parameter int LEN_W    = 4,
   parameter int TX_DEPTH = 8,
   parameter int RX_DEPTH = 8,
   parameter int PRE_W    = 8,
   parameter int SCR_W    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic                cpol,
   input  logic                cpha,
   input  logic [LEN_W-1:0]    len_m1,
   input  logic [PRE_W-1:0]    prescale,
   input  logic [SCR_W-1:0]    scr,
   input  logic                tx_wr,
   input  logic [MAX_BITS-1:0] tx_data,
   output logic                tx_not_full,
   input  logic                rx_rd,
   output logic [MAX_BITS-1:0] rx_data,
   output logic                rx_not_empty,
   output logic                busy,
   output logic                overrun,
   input  logic                overrun_clr,
   input  logic                tx_dma_en,
   input  logic                rx_dma_en,
   output logic                tx_dma_req,
   output logic                rx_dma_req,
   output logic                sclk,
   output logic                mosi,
   input  logic                miso,
   output logic                cs_n
);
   logic                tx_full, tx_empty, rx_full, rx_empty;
   logic                tx_pop, tick, done;
   logic [MAX_BITS-1:0] tx_head, rx_word;

   spi_fifo #(.WIDTH(MAX_BITS), .DEPTH(TX_DEPTH)) u_txq (
      .clk, .rst_n, .wr(tx_wr), .wdata(tx_data), .rd(tx_pop),
      .rdata(tx_head), .full(tx_full), .empty(tx_empty));

   spi_fifo #(.WIDTH(MAX_BITS), .DEPTH(RX_DEPTH)) u_rxq (
      .clk, .rst_n, .wr(done && !rx_full), .wdata(rx_word), .rd(rx_rd),
      .rdata(rx_data), .full(rx_full), .empty(rx_empty));

   spi_clkdiv #(.PRE_W(PRE_W), .SCR_W(SCR_W)) u_div (
      .clk, .rst_n, .run(busy), .prescale, .scr, .tick);

   spi_shifter #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_shift (
      .clk, .rst_n, .enable, .cpol, .cpha, .len_m1, .tick,
      .tx_empty, .tx_word(tx_head), .tx_pop, .busy, .done, .rx_word,
      .sclk, .mosi, .miso, .cs_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                overrun <= 1'b0;
      else if (done && rx_full)  overrun <= 1'b1;
      else if (overrun_clr)      overrun <= 1'b0;
   end

   assign tx_not_full  = !tx_full;
   assign rx_not_empty = !rx_empty;
   assign tx_dma_req   = tx_dma_en && !tx_full;
   assign rx_dma_req   = rx_dma_en && !rx_empty;

   // R7: a word finishing into a full receive queue raises overrun
   a_r7_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rx_full) |=> overrun);
   // R8: overrun only falls after a clear request
   a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !overrun_clr) |=> overrun);
   // R10: no frame begins while disabled
   a_r10_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !busy) |=> !busy);
endmodule

// File: tb/tb_spi_master_ctrl.sv
module tb_spi_master_ctrl;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        enable = 0, cpol = 0, cpha = 0, tx_wr = 0, rx_rd = 0, overrun_clr = 0;
   logic        tx_dma_en = 0, rx_dma_en = 0;
   logic [3:0]  len_m1 = 4'd7;
   logic [7:0]  prescale = 8'd2, scr = 8'd0;
   logic [15:0] tx_data = '0, rx_data;
   logic        tx_not_full, rx_not_empty, busy, overrun, tx_dma_req, rx_dma_req;
   logic        sclk, mosi, cs_n, miso;
   int          n_chk = 0, n_fail = 0;
   bit          finished = 0;

   assign miso = mosi;
   always #4 clk = ~clk;

   spi_master_ctrl dut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_word(input logic [15:0] d);
      @(negedge clk); tx_data = d; tx_wr = 1;
      @(negedge clk); tx_wr = 0;
   endtask

   task automatic rd_word(input string req, input logic [15:0] exp);
      @(negedge clk);
      chk(req, {31'd0, rx_not_empty}, 32'd1);
      chk(req, {16'd0, rx_data}, {16'd0, exp});
      rx_rd = 1;
      @(negedge clk); rx_rd = 0;
   endtask

   task automatic wait_idle();
      repeat (3) @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R9 reset busy", {31'd0, busy}, 0);
      chk("R4 reset cs_n", {31'd0, cs_n}, 1);
      chk("R3 reset sclk", {31'd0, sclk}, 0);
      chk("R5 reset tx_not_full", {31'd0, tx_not_full}, 1);
      chk("R6 reset rx_not_empty", {31'd0, rx_not_empty}, 0);
      chk("R8 reset overrun", {31'd0, overrun}, 0);
      chk("R12 reset rx_data", {16'd0, rx_data}, 0);
      chk("R11 reset dma", {30'd0, tx_dma_req, rx_dma_req}, 0);
   endtask

   task automatic t_loop8();
      enable = 1; cpol = 0; cpha = 0; len_m1 = 7; prescale = 2; scr = 0;
      wr_word(16'h00A5);
      while (cs_n) @(negedge clk);
      chk("R4 mosi MSB before first edge", {31'd0, mosi}, 1);
      chk("R4 sclk idle at frame start", {31'd0, sclk}, 0);
      wait_idle();
      rd_word("R2 loop 8-bit A5", 16'h00A5);
      wr_word(16'h013C);
      wait_idle();
      rd_word("R2 loop 8-bit masked", 16'h003C);
   endtask

   task automatic t_modes();
      cpol = 1; cpha = 1; len_m1 = 11;
      @(negedge clk);
      chk("R3 idle sclk with cpol=1", {31'd0, sclk}, 1);
      wr_word(16'h0ABC); wait_idle();
      rd_word("R3 mode 3 12-bit", 16'h0ABC);
      cpol = 0; cpha = 1; len_m1 = 1;
      wr_word(16'h001D); wait_idle();
      rd_word("R2 short length clamps to 4 bits", 16'h000D);
      cpol = 1; cpha = 0; len_m1 = 15;
      wr_word(16'hBEEF); wait_idle();
      rd_word("R3 mode 2 16-bit", 16'hBEEF);
      cpol = 0; cpha = 0;
      wr_word(16'h8001); wait_idle();
      rd_word("R2 mode 0 16-bit", 16'h8001);
      len_m1 = 7;
   endtask

   task automatic measure(input logic [7:0] p, input logic [7:0] s, input int exp, input string req);
      int cyc = 0, r1 = -1, r2 = -1;
      logic prev;
      prescale = p; scr = s;
      wr_word(16'h0055);
      prev = sclk;
      while (r2 < 0 && cyc < 5000) begin
         @(negedge clk); cyc++;
         if (!prev && sclk) begin
            if (r1 < 0) r1 = cyc; else r2 = cyc;
         end
         prev = sclk;
      end
      chk(req, r2 - r1, exp);
      wait_idle();
      rd_word("R1 frame intact", 16'h0055);
   endtask

   task automatic t_rate();
      measure(8'd5, 8'd2, 12, "R1 prescale 5 scr 2");
      measure(8'd0, 8'd0, 2, "R1 prescale 0 acts as 2");
      measure(8'd6, 8'd0, 6, "R1 prescale 6 scr 0");
      prescale = 2; scr = 0;
   endtask

   task automatic t_fill_disabled();
      enable = 0; tx_dma_en = 1; rx_dma_en = 1;
      @(negedge clk);
      chk("R11 tx dma with room", {31'd0, tx_dma_req}, 1);
      for (int i = 0; i < 8; i++) wr_word(16'h0010 + 16'(i));
      chk("R5 tx_not_full at 8", {31'd0, tx_not_full}, 0);
      chk("R11 tx dma when full", {31'd0, tx_dma_req}, 0);
      wr_word(16'h00EE);
      repeat (20) @(negedge clk);
      chk("R10 no busy while disabled", {31'd0, busy}, 0);
      chk("R10 cs_n high while disabled", {31'd0, cs_n}, 1);
      chk("R11 rx dma empty", {31'd0, rx_dma_req}, 0);
      enable = 1;
      wait_idle();
      chk("R11 rx dma with data", {31'd0, rx_dma_req}, 1);
      for (int i = 0; i < 8; i++) rd_word("R6 queue order", 16'h0010 + 16'(i));
      @(negedge clk);
      chk("R5 ninth write discarded", {31'd0, rx_not_empty}, 0);
      chk("R7 no overrun at 8", {31'd0, overrun}, 0);
      tx_dma_en = 0; rx_dma_en = 0;
   endtask

   task automatic t_busy();
      prescale = 4; scr = 1; len_m1 = 15;
      wr_word(16'h1234);
      wr_word(16'h5678);
      repeat (160) @(negedge clk);
      chk("R9 busy during last frame", {31'd0, busy}, 1);
      chk("R9 tx queue drained", {31'd0, tx_not_full}, 1);
      chk("R4 cs_n low in frame", {31'd0, cs_n}, 0);
      wait_idle();
      chk("R9 busy low after last frame", {31'd0, busy}, 0);
      rd_word("R9 frame 1", 16'h1234);
      rd_word("R9 frame 2", 16'h5678);
      prescale = 2; scr = 0; len_m1 = 7;
   endtask

   task automatic t_overrun();
      for (int i = 0; i < 8; i++) wr_word(16'h0040 + 16'(i));
      wait_idle();
      chk("R7 no overrun when just full", {31'd0, overrun}, 0);
      wr_word(16'h00A1);
      wr_word(16'h00A2);
      wait_idle();
      chk("R7 overrun set", {31'd0, overrun}, 1);
      chk("R7 shifting finished", {31'd0, busy}, 0);
      for (int i = 0; i < 8; i++) rd_word("R7 kept words", 16'h0040 + 16'(i));
      @(negedge clk);
      chk("R7 dropped words absent", {31'd0, rx_not_empty}, 0);
      chk("R8 overrun survives reads", {31'd0, overrun}, 1);
      repeat (5) @(negedge clk);
      chk("R8 overrun still set", {31'd0, overrun}, 1);
      overrun_clr = 1; @(negedge clk); overrun_clr = 0;
      chk("R8 overrun cleared", {31'd0, overrun}, 0);
   endtask

   task automatic t_empty_read();
      @(negedge clk);
      chk("R12 empty rx_data", {16'd0, rx_data}, 0);
      rx_rd = 1; @(negedge clk); rx_rd = 0;
      chk("R12 still empty", {31'd0, rx_not_empty}, 0);
      chk("R12 overrun untouched", {31'd0, overrun}, 0);
      wr_word(16'h0077); wait_idle();
      rd_word("R12 queue intact after empty read", 16'h0077);
      @(negedge clk);
      chk("R12 single entry", {31'd0, rx_not_empty}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_loop8();
      t_modes();
      t_rate();
      t_fill_disabled();
      t_busy();
      t_overrun();
      t_empty_read();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule